// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Vector Controller

This block picks which of eight interrupt sources an 8-bit microcontroller core services next. The sources have a fixed index order: external 0, timer 0, external 1, timer 1, serial port, timer 2, external 2 and HDLC. Each source presents a request flag at the block's input. Software sets the per-source masks, the global enable and the per-source priority level through a small register port that holds two byte-wide registers.

The block raises one request line and gives the vector address and level of the winning source in the same cycle. It has two priority levels. It tracks which levels are currently in service, using the core's acknowledge and return strobes. This lets a high-level request interrupt a low-level handler. A request can never interrupt a handler of its own level, and nothing can interrupt a high-level handler. The HDLC source is not masked from the enable register. It is masked by a separate input that comes from the HDLC control logic.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the mask register and the level register both read 0x00, `irq` is 0 and no level is in service.
- R2: A write with `reg_sel`=0 loads the mask register and a write with `reg_sel`=1 loads the level register. The write takes effect at the clock edge. `reg_rdata` shows the register that `reg_sel` selects, with no delay.
- R3: Source index i (0 to 7) appears on bit i of `req_flags`. Its vector is 0x03 + 8*i, so the vectors run 0x03, 0x0B, ... 0x3B.
- R4: When several eligible requests share the winning level, the one with the lowest source index is granted.
- R5: An eligible high-level request wins over any low-level request. It is granted while only the low level is in service.
- R6: While bit 7 of the mask register (the global enable) is 0, `irq` stays 0 whatever the requests are.
- R7: Mask register bits 0 to 6 enable sources 0 to 6 one-for-one. With bit 6 clear, a request from external 2 (source 6) is never granted.
- R8: Source 7 (HDLC) is enabled only by the `hdlc_en` input. No bit of the mask register other than the global enable affects it.
- R9: No request is granted while a level equal to or higher than its own is in service.
- R10: `ack` in a cycle where `irq` is 1 marks the granted level as in service from the next edge on. `ack` while `irq` is 0 has no effect.
- R11: `reti` clears the in-service bit of the high level if that bit is set. Otherwise it clears the in-service bit of the low level.
- R12: `irq_level` equals the level-register bit of the granted source (1 = high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mask, 1 level |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| req_flags | input | 8 | Request flags, bit i = source i |
| hdlc_en | input | 1 | HDLC source enable from the HDLC control register |
| ack | input | 1 | Core accepts the current grant |
| reti | input | 1 | Core returns from a handler |
| irq | output | 1 | Interrupt request to the core |
| vector | output | 8 | Vector address of the granted source |
| irq_level | output | 1 | Level of the granted source |

## Verification
Single requests on the lowest and highest sources check the vector formula and the special HDLC mask path. Several requests at once show whether the lowest index wins within a level or whether the level comes first. The masking patterns (global enable off, external 2 off, HDLC mask off with its flag raised) show which enable each source really follows. A nested sequence checks the in-service tracking: a low-level grant is acknowledged, then a high-level grant, then two returns. This sequence separates same-level blocking from cross-level preemption, and shows the order in which returns clear the levels.

// File: rtl/irq_vec_pkg.sv
// Package: shared parameters and helpers for the interrupt vector controller.
// Assumes sources are indexed in their fixed service order, index 0 first.
package irq_vec_pkg;
    localparam int N_SRC      = 8;
    localparam int IDX_W      = $clog2(N_SRC);
    localparam int DW         = 8;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
    localparam int GEN_BIT    = 7;
    localparam int HDLC_IDX   = 7;

    typedef logic [IDX_W-1:0] src_idx_t;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
    } pick_t;

    // Vector address of a source index.
    function automatic logic [DW-1:0] vec_of(input src_idx_t idx);
        return DW'(VEC_BASE + VEC_STRIDE * int'(idx));
    endfunction
endpackage

// File: rtl/irq_regs.sv
// Module: software-visible mask and level registers.
// Assumes one write per cycle; read data is combinational from reg_sel.
module irq_regs
    import irq_vec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] level_q
);
    // Register update on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            level_q <= '0;
        end else if (wr) begin
            if (sel) level_q <= wdata;
            else     mask_q  <= wdata;
        end
    end

    // Read multiplexer.
    always_comb rdata = sel ? level_q : mask_q;
endmodule

// File: rtl/irq_pick.sv
// Module: fixed-order picker, returns the lowest set index of a request vector.
// Assumes N requests; valid is 0 when no bit is set.
module irq_pick
    import irq_vec_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic [N-1:0] req,
    output pick_t        pick
);
    // Scan from highest index down so the lowest set index is kept.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.idx   = src_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_insvc.sv
// Module: in-service tracker for the two priority levels.
// Assumes reti is applied before a same-cycle acknowledge takes effect.
module irq_insvc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant,
    input  logic       grant_lvl,
    input  logic       ack,
    input  logic       reti,
    output logic [1:0] insvc_q
);
    logic [1:0] insvc_d;

    // Next-state: return clears the topmost active level, then acknowledge sets.
    always_comb begin
        insvc_d = insvc_q;
        if (reti) begin
            if (insvc_q[1]) insvc_d[1] = 1'b0;
            else            insvc_d[0] = 1'b0;
        end
        if (ack && grant) insvc_d[grant_lvl] = 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) insvc_q <= '0;
        else        insvc_q <= insvc_d;
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Module: two-level prioritized interrupt vector controller, eight sources.
// Assumes request flags are held by the peripherals until serviced; grant,
// vector and level are combinational from registers and current inputs.
module irq_vec_ctrl
    import irq_vec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [7:0]    req_flags,
    input  logic          hdlc_en,
    input  logic          ack,
    input  logic          reti,
    output logic          irq,
    output logic [7:0]    vector,
    output logic          irq_level
);
    logic [DW-1:0]    mask_q, level_q;
    logic [N_SRC-1:0] src_en, eligible, hi_req, lo_req;
    logic [1:0]       insvc_q;
    pick_t            hi_pick, lo_pick;
    logic             take_hi, take_lo;
    src_idx_t         win_idx;

    irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .mask_q(mask_q), .level_q(level_q)
    );

    // Per-source enables: HDLC takes its own mask, the rest map one-for-one.
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_en
            if (g == HDLC_IDX) begin : g_hdlc
                assign src_en[g] = hdlc_en;
            end else begin : g_std
                assign src_en[g] = mask_q[g];
            end
        end
    endgenerate

    // Eligible requests split by level.
    always_comb begin
        eligible = req_flags & src_en & {N_SRC{mask_q[GEN_BIT]}};
        hi_req   = eligible & level_q;
        lo_req   = eligible & ~level_q;
    end

    irq_pick #(.N(N_SRC)) u_pick_hi (.req(hi_req), .pick(hi_pick));
    irq_pick #(.N(N_SRC)) u_pick_lo (.req(lo_req), .pick(lo_pick));

    // Level arbitration against what is in service.
    always_comb begin
        take_hi   = hi_pick.valid && !insvc_q[1];
        take_lo   = !take_hi && lo_pick.valid && (insvc_q == 2'b00);
        win_idx   = take_hi ? hi_pick.idx : lo_pick.idx;
        irq       = take_hi || take_lo;
        irq_level = take_hi;
        vector    = irq ? vec_of(win_idx) : '0;
    end

    irq_insvc u_insvc (
        .clk(clk), .rst_n(rst_n), .grant(irq), .grant_lvl(irq_level),
        .ack(ack), .reti(reti), .insvc_q(insvc_q)
    );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
// Checker: temporal properties of the interrupt vector controller, bound to the top.
module irq_vec_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] mask_q,
    input logic [1:0] insvc_q,
    input logic       irq,
    input logic [7:0] vector,
    input logic       irq_level,
    input logic       ack,
    input logic       reti
);
    // R6
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[7] |-> !irq);
    // R3
    vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vector[2:0] == 3'd3 && vector <= 8'h3B));
    // R9
    hi_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_q[1] |-> !irq);
    // R9
    lo_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_q[0] && irq) |-> irq_level);
    // R10
    ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !reti) |=> insvc_q[$past(irq_level)]);
    // R11
    reti_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack && insvc_q[1]) |=> (!insvc_q[1] && insvc_q[0] == $past(insvc_q[0])));
    // R11
    reti_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack && !insvc_q[1]) |=> (insvc_q == 2'b00));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .insvc_q(insvc_q),
    .irq(irq), .vector(vector), .irq_level(irq_level),
    .ack(ack), .reti(reti)
);

// File: tb/irq_vec_ctrl_bench.sv
// Scoreboard bench: the driver queues expected outputs, the monitor compares them.
module irq_vec_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [7:0] req_flags = '0;
    logic       hdlc_en = 1'b0, ack = 1'b0, reti = 1'b0;
    logic       irq, irq_level;
    logic [7:0] vector;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        string      tag;
        logic       e_irq;
        logic [7:0] e_vec;
        logic       e_lvl;
        logic [7:0] e_rd;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    irq_vec_ctrl u_irq_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_flags(req_flags),
        .hdlc_en(hdlc_en), .ack(ack), .reti(reti),
        .irq(irq), .vector(vector), .irq_level(irq_level)
    );

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe(input logic a, input logic r);
        @(negedge clk);
        ack = a; reti = r;
        @(negedge clk);
        ack = 1'b0; reti = 1'b0;
    endtask

    // Drive inputs and queue what the outputs must show.
    task automatic expect_out(input string tag, input logic [7:0] req, input logic he,
                              input logic sel, input logic ei, input logic [7:0] ev,
                              input logic el, input logic [7:0] erd);
        item_t it;
        @(negedge clk);
        req_flags = req; hdlc_en = he; reg_sel = sel;
        it.tag = tag; it.e_irq = ei; it.e_vec = ev; it.e_lvl = el; it.e_rd = erd;
        sb.push_back(it);
    endtask

    // Monitor: compare queued items away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if (irq !== it.e_irq || (it.e_irq && (vector !== it.e_vec || irq_level !== it.e_lvl))
                    || reg_rdata !== it.e_rd) begin
                    bad++;
                    $display("FAIL %s: irq=%0b vec=%h lvl=%0b rd=%h expected irq=%0b vec=%h lvl=%0b rd=%h",
                             it.tag, irq, vector, irq_level, reg_rdata,
                             it.e_irq, it.e_vec, it.e_lvl, it.e_rd);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        expect_out("R1 mask reset", 8'hFF, 1'b1, 1'b0, 0, 8'h00, 0, 8'h00);
        expect_out("R1 level reset", 8'h00, 1'b0, 1'b1, 0, 8'h00, 0, 8'h00);
        wr(1'b0, 8'h7F);
        expect_out("R6 global off", 8'hFF, 1'b1, 1'b0, 0, 8'h00, 0, 8'h7F);
        wr(1'b0, 8'hFF);
        expect_out("R2 mask readback", 8'h00, 1'b0, 1'b0, 0, 8'h00, 0, 8'hFF);
        expect_out("R3 source0", 8'h01, 1'b0, 1'b0, 1, 8'h03, 0, 8'hFF);
        expect_out("R3 R8 hdlc on", 8'h80, 1'b1, 1'b0, 1, 8'h3B, 0, 8'hFF);
        expect_out("R8 hdlc off", 8'h80, 1'b0, 1'b0, 0, 8'h00, 0, 8'hFF);
        expect_out("R4 lowest of 5,6", 8'h60, 1'b0, 1'b0, 1, 8'h2B, 0, 8'hFF);
        expect_out("R4 all", 8'hFF, 1'b1, 1'b0, 1, 8'h03, 0, 8'hFF);
        wr(1'b0, 8'hBF);
        expect_out("R7 ext2 masked", 8'h40, 1'b0, 1'b0, 0, 8'h00, 0, 8'hBF);
        expect_out("R7 serial passes", 8'h50, 1'b0, 1'b0, 1, 8'h23, 0, 8'hBF);
        wr(1'b0, 8'h80);
        expect_out("R8 hdlc mask-independent", 8'h80, 1'b1, 1'b0, 1, 8'h3B, 0, 8'h80);
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'h40);
        expect_out("R2 level readback", 8'h00, 1'b0, 1'b1, 0, 8'h00, 0, 8'h40);
        expect_out("R5 R12 high first", 8'h41, 1'b0, 1'b1, 1, 8'h33, 1, 8'h40);
        // R10 ack without a grant is ignored.
        expect_out("R10 idle", 8'h00, 1'b0, 1'b1, 0, 8'h00, 0, 8'h40);
        strobe(1'b1, 1'b0);
        expect_out("R10 stray ack ignored", 8'h01, 1'b0, 1'b1, 1, 8'h03, 0, 8'h40);
        strobe(1'b1, 1'b0);
        expect_out("R9 same level blocked", 8'h01, 1'b0, 1'b1, 0, 8'h00, 0, 8'h40);
        expect_out("R5 preempt low", 8'h41, 1'b0, 1'b1, 1, 8'h33, 1, 8'h40);
        strobe(1'b1, 1'b0);
        expect_out("R9 high in service", 8'h41, 1'b0, 1'b1, 0, 8'h00, 0, 8'h40);
        strobe(1'b0, 1'b1);
        expect_out("R11 high cleared", 8'h41, 1'b0, 1'b1, 1, 8'h33, 1, 8'h40);
        expect_out("R11 low still held", 8'h01, 1'b0, 1'b1, 0, 8'h00, 0, 8'h40);
        strobe(1'b0, 1'b1);
        expect_out("R11 low cleared", 8'h01, 1'b0, 1'b1, 1, 8'h03, 0, 8'h40);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule